// File: doc/BRIEF.md
# Initiator Request Queue with Priority Service and Overflow Drop

This block sits at one initiator port of an interconnect and holds transactions until the arbiter grants the port. Each transaction has a command bit (read or write), a byte count, a priority, a source ID and a destination ID. The number of transactions that can wait is set by a per-initiator limit, `QUEUE_LIMIT`, which defaults to 2. The port raises `req_pending` while anything is waiting. Each grant forwards one waiting transaction: the one with the highest priority, taking the oldest when priorities are equal.

The input is a valid/ready stream, and a transfer happens in any cycle where `in_valid` and `in_ready` are both high. In the normal mode `in_ready` stays high at all times. A transaction that arrives while the queue is full is accepted at the interface, then discarded and counted in a saturating drop counter. In the throttled mode (`throttle_en` high) only one transaction may be outstanding. `in_ready` goes low while an entry waits, which back-pressures the source instead of dropping its requests.

The dequeue side has no handshake. The `out_*` fields show the entry that will be forwarded, and they are meaningful only while `req_pending` is high. A `grant` pulse in such a cycle removes that entry at the clock edge.

Top module: `init_req_queue`

## Requirements
- R1: After the asynchronous active-low reset, the queue is empty, `req_pending` is low and `drop_count` is 0.
- R2: `req_pending` is high exactly when at least one entry is waiting.
- R3: While `req_pending` is high, the `out_*` fields present the waiting entry with the largest `prio` value (unsigned; larger means more urgent). A `grant` in that cycle removes that entry at the clock edge.
- R4: Among waiting entries of equal priority, the one accepted earliest is presented and forwarded first.
- R5: With `throttle_en` low, `in_ready` is always high and up to `QUEUE_LIMIT` entries are held.
- R6: A transfer that arrives while `QUEUE_LIMIT` entries wait, and no grant is taken in that cycle, is discarded. `drop_count` rises by one and the waiting entries are unchanged.
- R7: When the queue is full and a grant is taken in the same cycle as an incoming transfer, the incoming transfer is accepted and nothing is dropped.
- R8: `drop_count` saturates at 2^DROP_W-1 instead of wrapping.
- R9: With `throttle_en` high, `in_ready` is low while any entry waits and high when the queue is empty, so at most one entry is outstanding.
- R10: A `grant` while `req_pending` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle_en | input | 1 | Single-outstanding mode with back-pressure |
| in_valid | input | 1 | Incoming transaction valid |
| in_ready | output | 1 | Queue takes the transaction |
| in_cmd | input | 1 | Command: 0 read, 1 write |
| in_bytes | input | BYTES_W | Byte count |
| in_prio | input | PRIO_W | Priority, larger is more urgent |
| in_src | input | ID_W | Source ID |
| in_dst | input | ID_W | Destination ID |
| req_pending | output | 1 | At least one entry waiting |
| grant | input | 1 | Arbiter grant, removes the presented entry |
| out_cmd | output | 1 | Command of presented entry |
| out_bytes | output | BYTES_W | Byte count of presented entry |
| out_prio | output | PRIO_W | Priority of presented entry |
| out_src | output | ID_W | Source ID of presented entry |
| out_dst | output | ID_W | Destination ID of presented entry |
| drop_count | output | DROP_W | Saturating count of discarded arrivals |

## Verification
The bench builds the block with `QUEUE_LIMIT` set to 4, so that four entries can be reordered against each other and ties of equal priority can be formed. It sets `PRIO_W` to 3, so random priorities collide often. `DROP_W` is set to 3, so the drop counter reaches its ceiling of 7 after a short overflow burst and saturation can be observed. A behavioural queue model is compared against the block on every clock. Its random stimulus mixes simultaneous grant-and-arrival on a full queue, grants on an empty queue and toggling of the throttled mode.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic {
    RQ_READ  = 1'b0,
    RQ_WRITE = 1'b1
  } rq_cmd_e;

  function automatic int unsigned rq_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rq_pick.sv
module rq_pick #(
  parameter int DEPTH = 2,
  parameter int PW    = 4,
  parameter int CW    = 2,
  parameter int XW    = 1
) (
  input  logic [PW-1:0] prio [DEPTH],
  input  logic [CW-1:0] count,
  output logic [XW-1:0] sel
);
  logic [PW-1:0] best;

  // scan oldest to newest; strict compare keeps the oldest on ties
  always_comb begin
    sel  = '0;
    best = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(count)) begin
        if (i == 0 || prio[i] > best) begin
          sel  = XW'(i);
          best = prio[i];
        end
      end
    end
  end
endmodule

// File: rtl/rq_store.sv
module rq_store #(
  parameter int DEPTH = 2,
  parameter int DW    = 8,
  parameter int PW    = 4,
  parameter int CW    = 2,
  parameter int XW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [PW-1:0] push_prio,
  input  logic          pop,
  input  logic [XW-1:0] pop_idx,
  output logic [DW-1:0] slot_data [DEPTH],
  output logic [PW-1:0] slot_prio [DEPTH],
  output logic [CW-1:0] count
);
  logic [DW-1:0] n_data [DEPTH];
  logic [PW-1:0] n_prio [DEPTH];
  logic [CW-1:0] base;

  // slots are kept in arrival order; removal closes the gap
  always_comb begin
    n_data = slot_data;
    n_prio = slot_prio;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          n_data[i] = slot_data[i+1];
          n_prio[i] = slot_prio[i+1];
        end
      end
    end
    base = count - (pop ? CW'(1) : CW'(0));
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(base)) begin
          n_data[i] = push_data;
          n_prio[i] = push_prio;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_data[i] <= '0;
        slot_prio[i] <= '0;
      end
    end else begin
      count     <= base + (push ? CW'(1) : CW'(0));
      slot_data <= n_data;
      slot_prio <= n_prio;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R5

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && int'(count) == DEPTH) |=> int'(count) == DEPTH); // R7
endmodule

// File: rtl/rq_drop_ctr.sv
module rq_drop_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      value <= '0;
    else if (hit && value != TOP)
      value <= value + W'(1);
  end

  AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (value == TOP) |=> (value == TOP)); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && value != TOP) |=> (value == $past(value) + W'(1))); // R6
endmodule

// File: rtl/init_req_queue.sv
module init_req_queue #(
  parameter int QUEUE_LIMIT = 2,
  parameter int BYTES_W     = 16,
  parameter int PRIO_W      = 4,
  parameter int ID_W        = 8,
  parameter int DROP_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               throttle_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_cmd,
  input  logic [BYTES_W-1:0] in_bytes,
  input  logic [PRIO_W-1:0]  in_prio,
  input  logic [ID_W-1:0]    in_src,
  input  logic [ID_W-1:0]    in_dst,
  output logic               req_pending,
  input  logic               grant,
  output logic               out_cmd,
  output logic [BYTES_W-1:0] out_bytes,
  output logic [PRIO_W-1:0]  out_prio,
  output logic [ID_W-1:0]    out_src,
  output logic [ID_W-1:0]    out_dst,
  output logic [DROP_W-1:0]  drop_count
);
  import rq_pkg::*;

  localparam int CNTW = $clog2(QUEUE_LIMIT + 1);
  localparam int IDXW = rq_idx_width(QUEUE_LIMIT);
  localparam int PAYW = 1 + BYTES_W + 2 * ID_W;

  logic [PAYW-1:0]   slot_data [QUEUE_LIMIT];
  logic [PRIO_W-1:0] slot_prio [QUEUE_LIMIT];
  logic [CNTW-1:0]   count;
  logic [IDXW-1:0]   sel;
  logic              full, pop, push, lose;
  rq_cmd_e           head_cmd;

  assign full        = (count == CNTW'(QUEUE_LIMIT));
  assign req_pending = (count != '0);
  assign in_ready    = !throttle_en || !req_pending;
  assign pop         = grant && req_pending;
  assign push        = in_valid && in_ready && (!full || pop);
  assign lose        = in_valid && in_ready && full && !pop;

  rq_pick #(
    .DEPTH(QUEUE_LIMIT), .PW(PRIO_W), .CW(CNTW), .XW(IDXW)
  ) u_pick (
    .prio (slot_prio),
    .count(count),
    .sel  (sel)
  );

  rq_store #(
    .DEPTH(QUEUE_LIMIT), .DW(PAYW), .PW(PRIO_W), .CW(CNTW), .XW(IDXW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data({in_cmd, in_bytes, in_src, in_dst}),
    .push_prio(in_prio),
    .pop      (pop),
    .pop_idx  (sel),
    .slot_data(slot_data),
    .slot_prio(slot_prio),
    .count    (count)
  );

  rq_drop_ctr #(.W(DROP_W)) u_drop (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (lose),
    .value(drop_count)
  );

  assign head_cmd = rq_cmd_e'(slot_data[sel][PAYW-1]);
  assign out_cmd  = head_cmd;
  assign {out_bytes, out_src, out_dst} = slot_data[sel][PAYW-2:0];
  assign out_prio = slot_prio[sel];

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_pending && !in_valid) |=> !req_pending); // R10

  AST_THROTTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_en && req_pending && !grant) |=> (count == $past(count))); // R9

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && full && !grant) |=> full); // R6

  AST_PEND_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !full) |=> req_pending); // R2
endmodule

// File: tb/test_init_req_queue.sv
module test_init_req_queue;
  localparam int LIM = 4;
  localparam int BW  = 8;
  localparam int PW  = 3;
  localparam int IW  = 4;
  localparam int DW  = 3;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          throttle_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_cmd = 1'b0;
  logic [BW-1:0] in_bytes = '0;
  logic [PW-1:0] in_prio = '0;
  logic [IW-1:0] in_src = '0;
  logic [IW-1:0] in_dst = '0;
  logic          req_pending;
  logic          grant = 1'b0;
  logic          out_cmd;
  logic [BW-1:0] out_bytes;
  logic [PW-1:0] out_prio;
  logic [IW-1:0] out_src;
  logic [IW-1:0] out_dst;
  logic [DW-1:0] drop_count;

  always #2 clk = ~clk;

  init_req_queue #(
    .QUEUE_LIMIT(LIM), .BYTES_W(BW), .PRIO_W(PW), .ID_W(IW), .DROP_W(DW)
  ) i_init_req_queue (
    .clk(clk), .rst_n(rst_n), .throttle_en(throttle_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_cmd(in_cmd),
    .in_bytes(in_bytes), .in_prio(in_prio), .in_src(in_src), .in_dst(in_dst),
    .req_pending(req_pending), .grant(grant),
    .out_cmd(out_cmd), .out_bytes(out_bytes), .out_prio(out_prio),
    .out_src(out_src), .out_dst(out_dst), .drop_count(drop_count)
  );

  typedef struct {
    int cmd; int bytes; int prio; int src; int dst;
  } ent_t;

  ent_t mq[$];
  int   mdrop = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  function automatic int best_idx();
    int b = 0;
    for (int i = 1; i < mq.size(); i++)
      if (mq[i].prio > mq[b].prio) b = i;
    return b;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      mdrop = 0;
    end else begin
      bit pend, rdy, g, full;
      ent_t e;
      pend = mq.size() > 0;
      rdy  = !throttle_en || !pend;
      g    = grant && pend;
      full = mq.size() == LIM;
      if (g) mq.delete(best_idx());
      if (in_valid && rdy) begin
        if (!full || g) begin
          e.cmd = int'(in_cmd); e.bytes = int'(in_bytes); e.prio = int'(in_prio);
          e.src = int'(in_src); e.dst = int'(in_dst);
          mq.push_back(e);
        end else if (mdrop < DMAX) mdrop++;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ep, er;
      ep = mq.size() > 0;
      er = !throttle_en || !ep;
      chk(req_pending == ep, "R2 req_pending", int'(req_pending), int'(ep));
      if (throttle_en) chk(in_ready == er, "R9 in_ready", int'(in_ready), int'(er));
      else             chk(in_ready == er, "R5 in_ready", int'(in_ready), int'(er));
      chk(int'(drop_count) == mdrop, "R6 R8 drop_count", int'(drop_count), mdrop);
      if (ep) begin
        ent_t h;
        h = mq[best_idx()];
        chk(int'(out_prio) == h.prio, "R3 out_prio", int'(out_prio), h.prio);
        chk(int'(out_src) == h.src, "R3 R4 out_src", int'(out_src), h.src);
        chk(int'(out_dst) == h.dst, "R3 out_dst", int'(out_dst), h.dst);
        chk(int'(out_bytes) == h.bytes, "R3 out_bytes", int'(out_bytes), h.bytes);
        chk(int'(out_cmd) == h.cmd, "R3 out_cmd", int'(out_cmd), h.cmd);
      end
    end
  end

  task automatic drive(input bit v, input int p, input int s, input bit g);
    @(posedge clk);
    #1;
    in_valid = v;
    in_prio  = PW'(p);
    in_src   = IW'(s);
    in_dst   = IW'(s + 3);
    in_bytes = BW'(s * 8 + p);
    in_cmd   = s[0];
    grant    = g;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_pending == 1'b0, "R1 req_pending after reset", int'(req_pending), 0);
    chk(drop_count == '0, "R1 drop_count after reset", int'(drop_count), 0);

    // fill with mixed priorities, ties at 5
    drive(1, 2, 1, 0);
    drive(1, 5, 2, 0);
    drive(1, 5, 3, 0);
    drive(1, 1, 4, 0);
    // three arrivals on a full queue
    drive(1, 7, 9, 0);
    drive(1, 7, 9, 0);
    drive(1, 7, 9, 0);
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk(out_src == 4'd2, "R4 oldest of equal priority", int'(out_src), 2);
    chk(drop_count == 3'd3, "R6 drops on full", int'(drop_count), 3);
    repeat (4) drive(0, 0, 0, 1);

    // full queue, grant and arrival together
    for (int i = 0; i < LIM; i++) drive(1, 0, 5 + i, 0);
    drive(1, 7, 12, 1);
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk(out_src == 4'd12, "R7 arrival taken with grant", int'(out_src), 12);
    chk(drop_count == 3'd3, "R7 no drop on swap", int'(drop_count), 3);
    repeat (LIM) drive(0, 0, 0, 1);

    // overflow burst up to saturation
    for (int i = 0; i < LIM; i++) drive(1, i, i, 0);
    for (int i = 0; i < 10; i++) drive(1, 6, 15, 0);
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk(drop_count == 3'd7, "R8 drop_count saturates", int'(drop_count), 7);
    repeat (LIM) drive(0, 0, 0, 1);

    // grant with nothing waiting
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);
    drive(1, 3, 6, 0);
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk(req_pending == 1'b1, "R10 entry kept after idle grants", int'(req_pending), 1);
    chk(out_src == 4'd6, "R10 entry intact", int'(out_src), 6);
    drive(0, 0, 0, 1);

    // throttled mode
    @(posedge clk);
    #1 throttle_en = 1'b1;
    drive(1, 2, 7, 0);
    drive(1, 4, 8, 0);
    drive(1, 4, 8, 0);
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk(out_src == 4'd7, "R9 only first entry held", int'(out_src), 7);
    chk(in_ready == 1'b0, "R9 back-pressure", int'(in_ready), 0);
    drive(0, 0, 0, 1);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 99) < 3) begin
        @(posedge clk);
        #1 throttle_en = ~throttle_en;
      end
      drive($urandom_range(0, 99) < 70, int'($urandom_range(0, 7)),
            int'($urandom_range(0, 15)), $urandom_range(0, 99) < 40);
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    summary();
  end
endmodule